// File: doc/BRIEF.md
# Binary-Weighted Staircase Gate Generator

This block turns a signed reference sample into gate commands for a cascaded staircase inverter. The inverter stacks `MAG_BITS` half-bridge cells, cell i fed from a source worth 2^i units, and follows them with one full bridge that picks the output polarity. Each accepted sample is folded to its absolute value, scaled by a modulation index and cut down to a `MAG_BITS`-wide magnitude code. Bit i of that code is the gate of cell i, so the stack forms the binary value of the requested level. There is no carrier: the magnitude bits are the cell gates, and the sign of the level selects which diagonal pair of the full bridge conducts. With the default of four cells the output spans 31 levels, from -15 to +15 units.

The reference comes either from the external sample port or from an internal table. The table holds one half cycle of a sine and is replayed for both halves, with a half-cycle flag giving the sign. Amplitude and frequency follow the reference directly, because every strobe produces a new level. All gate outputs update together on the sample strobe. When the bridge polarity has to reverse, the block spends one sample period with both bridge legs and all cells off before it commits the new polarity.

Top module: `stepwave_gate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `cell_gate`, `leg_pos` and `leg_neg` are all 0 after that edge, even when `smp_valid` is high. The first strobe after reset commits its level directly, with no blanking period.
- R2: The outputs change only after a clock edge at which `smp_valid` is 1, and they appear after that edge. Without a strobe, changes on `smp_data`, `mod_index` or `use_table` leave all outputs unchanged.
- R3: In external mode (`use_table`=0), `smp_data` is 10-bit two's complement. The magnitude is min(|x|, 511). The scaled value is (magnitude * min(`mod_index`, 256)) >> 8, and the code is the scaled value >> 5 (truncation). `cell_gate[i]` carries code bit i, so +320 gives 4'b1010.
- R4: A level is negative only when the reference is negative and the code is nonzero. For a zero or positive level, `leg_pos`=1 and `leg_neg`=0. For a negative level, `leg_pos`=0 and `leg_neg`=1. A zero level has `cell_gate`=0, so a small negative sample such as -31 gives cells 0000 with `leg_pos`=1.
- R5: The sample -512 saturates to magnitude 511, which gives a code of 4'b1111 on the negative leg.
- R6: When a strobe asks for the opposite polarity from the one committed, the outputs after that strobe are `cell_gate`=0 with both legs 0. The next strobe commits its own level and polarity, whatever that polarity is.
- R7: `leg_pos` and `leg_neg` are never both 1, and neither leg turns on in the cycle right after the other leg was on.
- R8: In table mode (`use_table`=1), strobe number n after reset (counting only table-mode strobes) uses index k = n mod 32 and half flag h = (n / 32) mod 2. The magnitude is 511*16k(32-k) / (5*32*32 - 4k(32-k)) in integer division, and h=1 means a negative reference. `smp_data` is ignored. At `mod_index`=256, the peak code is 15, reached at k=16.
- R9: A modulation index below 256 lowers the highest level reached. At 128, a table half cycle peaks at code 7. Values above 256 act as 256, and 0 gives level 0.
- R10: The table index advances only on table-mode strobes. External-mode strobes in between leave it where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; one new level per strobe |
| use_table | input | 1 | 1 selects the internal half-sine table, 0 the external sample |
| smp_data | input | 10 | External reference sample, two's complement |
| mod_index | input | 9 | Modulation index, 256 means unity |
| cell_gate | output | 4 | Half-bridge cell gates, bit i drives the cell weighted 2^i |
| leg_pos | output | 1 | Full-bridge diagonal for zero and positive levels |
| leg_neg | output | 1 | Full-bridge diagonal for negative levels |

## Verification
A polarity reversal and an advance of the table position can fall on the same strobe. When the half-cycle flag turns negative, the first nonzero negative sample meets the blanking rule, so the strobe is spent with everything off while the table index still moves on. The bench provokes this by walking the table across its half-cycle wrap. It also interleaves external samples with table samples. It judges the outcome against a model built from the requirements, which expects the blank at the first nonzero negative entry, the committed level of the following entry, and no index movement during external strobes.

// File: rtl/stepgate_pkg.sv
package stepgate_pkg;

    // Decision taken by the bridge guard on each cycle
    typedef enum logic [1:0] {
        GA_HOLD   = 2'd0,
        GA_BLANK  = 2'd1,
        GA_COMMIT = 2'd2
    } guard_act_e;

    // Full-bridge diagonal pair drive
    typedef struct packed {
        logic pos;
        logic neg;
    } legs_t;

    localparam legs_t LEGS_OFF = '{pos: 1'b0, neg: 1'b0};

    // Rational half-sine approximation: 16k(D-k) / (5D^2 - 4k(D-k)), scaled by amax
    function automatic int unsigned half_sine_amp(int unsigned k, int unsigned depth,
                                                  int unsigned amax);
        longint prod;
        longint num;
        longint den;
        prod = longint'(k) * (longint'(depth) - longint'(k));
        num  = 64'sd16 * prod;
        den  = 64'sd5 * longint'(depth) * longint'(depth) - 64'sd4 * prod;
        return int'((longint'(amax) * num) / den);
    endfunction

endpackage

// File: rtl/stepgate_ref_src.sv
module stepgate_ref_src #(
    parameter int SAMPLE_W  = 10,
    parameter int TBL_DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic                use_table,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [SAMPLE_W-2:0] ref_mag,
    output logic                ref_neg
);
    localparam int          MAG_W    = SAMPLE_W - 1;
    localparam int          IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam int unsigned AMAX     = (1 << MAG_W) - 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_DEPTH - 1);

    // Half-cycle sine table, computed at elaboration
    logic [MAG_W-1:0] sine_rom [TBL_DEPTH];

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_rom
        localparam int unsigned AMP = stepgate_pkg::half_sine_amp(g, TBL_DEPTH, AMAX);
        assign sine_rom[g] = MAG_W'(AMP);
    end

    // Phase position and half-cycle flag
    logic [IDX_W-1:0] idx_q;
    logic             half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            half_q <= 1'b0;
        end else if (strobe && use_table) begin
            if (idx_q == IDX_LAST) begin
                idx_q  <= '0;
                half_q <= ~half_q;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // External path: absolute value with saturation of the most negative code
    logic [SAMPLE_W-1:0] ext_abs;
    logic [MAG_W-1:0]    ext_mag;

    always_comb begin
        if (smp_data[SAMPLE_W-1]) begin
            ext_abs = ~smp_data + SAMPLE_W'(1);
        end else begin
            ext_abs = smp_data;
        end
        if (ext_abs > SAMPLE_W'(AMAX)) begin
            ext_mag = MAG_W'(AMAX);
        end else begin
            ext_mag = ext_abs[MAG_W-1:0];
        end
    end

    always_comb begin
        if (use_table) begin
            ref_mag = sine_rom[idx_q];
            ref_neg = half_q;
        end else begin
            ref_mag = ext_mag;
            ref_neg = smp_data[SAMPLE_W-1];
        end
    end

endmodule

// File: rtl/stepgate_quant.sv
module stepgate_quant #(
    parameter int MAG_W    = 9,
    parameter int MAG_BITS = 4,
    parameter int MI_W     = 9
) (
    input  logic [MAG_W-1:0]    ref_mag,
    input  logic                ref_neg,
    input  logic [MI_W-1:0]     mod_index,
    output logic [MAG_BITS-1:0] code,
    output logic                lvl_neg
);
    localparam int              PROD_W   = MAG_W + MI_W;
    localparam logic [MI_W-1:0] MI_UNITY = MI_W'(1 << (MI_W - 1));

    logic [MI_W-1:0]   mi_eff;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  scaled;

    always_comb begin
        // Indices above unity are clipped so the magnitude never exceeds full scale
        mi_eff = (mod_index > MI_UNITY) ? MI_UNITY : mod_index;
        prod   = PROD_W'(ref_mag) * PROD_W'(mi_eff);
        scaled = prod[MI_W-1 +: MAG_W];
        // Keep the top bits: truncation toward zero
        code    = scaled[MAG_W-1 -: MAG_BITS];
        lvl_neg = ref_neg && (code != '0);
    end

endmodule

// File: rtl/stepgate_guard.sv
module stepgate_guard #(
    parameter int MAG_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [MAG_BITS-1:0] code,
    input  logic                tgt_neg,
    output logic [MAG_BITS-1:0] cell_gate,
    output logic                leg_pos,
    output logic                leg_neg
);
    import stepgate_pkg::*;

    guard_act_e act;
    legs_t      legs_q;
    legs_t      legs_d;
    logic       live_q;
    logic       blank_q;
    logic       pol_neg_q;

    always_comb begin
        if (!strobe) begin
            act = GA_HOLD;
        end else if (live_q && !blank_q && (tgt_neg != pol_neg_q)) begin
            act = GA_BLANK;
        end else begin
            act = GA_COMMIT;
        end
    end

    always_comb begin
        case (act)
            GA_BLANK:  legs_d = LEGS_OFF;
            GA_COMMIT: legs_d = '{pos: ~tgt_neg, neg: tgt_neg};
            default:   legs_d = legs_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            legs_q    <= LEGS_OFF;
            live_q    <= 1'b0;
            blank_q   <= 1'b0;
            pol_neg_q <= 1'b0;
        end else begin
            legs_q <= legs_d;
            case (act)
                GA_BLANK: begin
                    blank_q <= 1'b1;
                end
                GA_COMMIT: begin
                    blank_q   <= 1'b0;
                    pol_neg_q <= tgt_neg;
                    live_q    <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // One register per half-bridge cell
    for (genvar c = 0; c < MAG_BITS; c++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= 1'b0;
            end else if (act == GA_BLANK) begin
                cell_q <= 1'b0;
            end else if (act == GA_COMMIT) begin
                cell_q <= code[c];
            end
        end
        assign cell_gate[c] = cell_q;
    end

    assign leg_pos = legs_q.pos;
    assign leg_neg = legs_q.neg;

endmodule

// File: rtl/stepwave_gate_gen.sv
module stepwave_gate_gen #(
    parameter int MAG_BITS  = 4,
    parameter int SAMPLE_W  = 10,
    parameter int TBL_DEPTH = 32,
    parameter int MI_W      = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                use_table,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [MI_W-1:0]     mod_index,
    output logic [MAG_BITS-1:0] cell_gate,
    output logic                leg_pos,
    output logic                leg_neg
);
    localparam int MAG_W = SAMPLE_W - 1;

    logic [MAG_W-1:0]    ref_mag;
    logic                ref_neg;
    logic [MAG_BITS-1:0] code;
    logic                lvl_neg;

    stepgate_ref_src #(
        .SAMPLE_W (SAMPLE_W),
        .TBL_DEPTH(TBL_DEPTH)
    ) src_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (smp_valid),
        .use_table(use_table),
        .smp_data (smp_data),
        .ref_mag  (ref_mag),
        .ref_neg  (ref_neg)
    );

    stepgate_quant #(
        .MAG_W   (MAG_W),
        .MAG_BITS(MAG_BITS),
        .MI_W    (MI_W)
    ) quant_i (
        .ref_mag  (ref_mag),
        .ref_neg  (ref_neg),
        .mod_index(mod_index),
        .code     (code),
        .lvl_neg  (lvl_neg)
    );

    stepgate_guard #(
        .MAG_BITS(MAG_BITS)
    ) guard_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (smp_valid),
        .code     (code),
        .tgt_neg  (lvl_neg),
        .cell_gate(cell_gate),
        .leg_pos  (leg_pos),
        .leg_neg  (leg_neg)
    );

endmodule

// File: rtl/stepwave_gate_chk.sv
module stepwave_gate_chk #(
    parameter int MAG_BITS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [MAG_BITS-1:0] cell_gate,
    input logic                leg_pos,
    input logic                leg_neg
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_LOW: assert (cell_gate == '0 && !leg_pos && !leg_neg); // R1
        end
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(cell_gate) && $stable(leg_pos) && $stable(leg_neg))); // R2

    AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        leg_neg |-> (cell_gate != '0)); // R4

    AST_OFF_CELLS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!leg_pos && !leg_neg) |-> (cell_gate == '0)); // R6

    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(leg_pos && leg_neg)); // R7

    AST_NO_SWAP_POS: assert property (@(posedge clk) disable iff (rst)
        leg_pos |=> !leg_neg); // R7

    AST_NO_SWAP_NEG: assert property (@(posedge clk) disable iff (rst)
        leg_neg |=> !leg_pos); // R7

endmodule

bind stepwave_gate_gen stepwave_gate_chk #(.MAG_BITS(MAG_BITS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .smp_valid(smp_valid),
    .cell_gate(cell_gate),
    .leg_pos  (leg_pos),
    .leg_neg  (leg_neg)
);

// File: tb/stepwave_gate_gen_tb_top.sv
module stepwave_gate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_valid;
    logic       use_table;
    logic [9:0] smp_data;
    logic [8:0] mod_index;
    logic [3:0] cell_gate;
    logic       leg_pos;
    logic       leg_neg;

    always #5 clk = ~clk;

    stepwave_gate_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .use_table(use_table),
        .smp_data (smp_data),
        .mod_index(mod_index),
        .cell_gate(cell_gate),
        .leg_pos  (leg_pos),
        .leg_neg  (leg_neg)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Model state built from R6
    int m_live, m_blank, m_pol;
    // Table position from R8 and R10
    int tb_idx, tb_half;

    // sample, mod_index, expected cells, expected leg_pos, expected leg_neg
    localparam int VEC [14][5] = '{
        '{  320, 256, 10, 1, 0},  // R3 first strobe, 1010
        '{  511, 256, 15, 1, 0},  // R3 full scale
        '{   31, 256,  0, 1, 0},  // R4 zero level
        '{  -31, 256,  0, 1, 0},  // R4 small negative is zero level, positive leg
        '{  -32, 256,  0, 0, 0},  // R6 flip to negative: blank
        '{ -320, 256, 10, 0, 1},  // R6 commit negative
        '{ -512, 256, 15, 0, 1},  // R5 saturation
        '{    0, 256,  0, 0, 0},  // R6 flip to positive: blank
        '{   64, 256,  2, 1, 0},  // R6 commit positive
        '{  511, 128,  7, 1, 0},  // R9 half index
        '{  511, 511, 15, 1, 0},  // R9 index clipped to unity
        '{ -100, 256,  0, 0, 0},  // R6 blank
        '{  100, 256,  3, 1, 0},  // R6 commit after blank, same polarity as before
        '{  200,   0,  0, 1, 0}   // R9 zero index
    };

    task automatic check(string req, logic [3:0] ec, logic ep, logic en);
        n_chk++;
        if (cell_gate !== ec || leg_pos !== ep || leg_neg !== en) begin
            n_fail++;
            $display("FAIL %s: actual cells=%b pos=%b neg=%b expected cells=%b pos=%b neg=%b",
                     req, cell_gate, leg_pos, leg_neg, ec, ep, en);
        end
    endtask

    task automatic pulse(logic tbl, int sample, int mi);
        @(negedge clk);
        use_table = tbl;
        smp_data  = 10'(sample);
        mod_index = 9'(mi);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic model_reset();
        m_live  = 0;
        m_blank = 0;
        m_pol   = 0;
        tb_idx  = 0;
        tb_half = 0;
    endtask

    task automatic model(int code, int neg, output logic [3:0] ec, output logic ep,
                         output logic en);
        if (m_live != 0 && m_blank == 0 && neg != m_pol) begin
            m_blank = 1;
            ec = 4'd0; ep = 1'b0; en = 1'b0;
        end else begin
            m_blank = 0;
            m_pol   = neg;
            m_live  = 1;
            ec = 4'(code); ep = (neg == 0); en = (neg != 0);
        end
    endtask

    function automatic int ext_code(int s, int mi);
        int mag;
        int mic;
        mag = (s < 0) ? -s : s;
        if (mag > 511) mag = 511;
        mic = (mi > 256) ? 256 : mi;
        return ((mag * mic) / 256) / 32;
    endfunction

    function automatic int tbl_amp(int k);
        return (511 * 16 * k * (32 - k)) / (5 * 32 * 32 - 4 * k * (32 - k));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One table-mode strobe; smp_data is driven with a value that must be ignored (R8)
    task automatic tstep(string req, int mi, output int code_out);
        int         amp, mic, code, neg;
        logic [3:0] ec;
        logic       ep, en;
        pulse(1'b1, -512, mi);
        amp  = tbl_amp(tb_idx);
        mic  = (mi > 256) ? 256 : mi;
        code = ((amp * mic) / 256) / 32;
        neg  = (tb_half != 0 && code != 0) ? 1 : 0;
        model(code, neg, ec, ep, en);
        check($sformatf("%s idx=%0d half=%0d", req, tb_idx, tb_half), ec, ep, en);
        code_out = code;
        if (tb_idx == 31) begin
            tb_idx  = 0;
            tb_half = 1 - tb_half;
        end else begin
            tb_idx++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int         peak;
        int         c;
        logic [3:0] ec;
        logic       ep, en;

        rst       = 1'b1;
        smp_valid = 1'b0;
        use_table = 1'b0;
        smp_data  = '0;
        mod_index = 9'd256;
        repeat (3) @(negedge clk);
        check("R1 reset state", 4'd0, 1'b0, 1'b0);
        rst = 1'b0;
        model_reset();

        // Vector table walk (R3 R4 R5 R6 R9)
        for (int i = 0; i < 14; i++) begin
            pulse(1'b0, VEC[i][0], VEC[i][1]);
            check($sformatf("vector %0d R3 R4 R5 R6 R9", i),
                  4'(VEC[i][2]), VEC[i][3] != 0, VEC[i][4] != 0);
        end

        // R2: inputs move without a strobe
        pulse(1'b0, 320, 256);
        check("R2 strobe", 4'b1010, 1'b1, 1'b0);
        @(negedge clk);
        smp_data  = 10'(-512);
        mod_index = 9'd0;
        use_table = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 no strobe hold", 4'b1010, 1'b1, 1'b0);

        // R1: reset with strobe active, then direct commit of a negative level
        @(negedge clk);
        rst       = 1'b1;
        smp_valid = 1'b1;
        use_table = 1'b0;
        smp_data  = 10'd511;
        mod_index = 9'd256;
        @(negedge clk);
        check("R1 reset during strobe", 4'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1 reset held", 4'd0, 1'b0, 1'b0);
        smp_valid = 1'b0;
        rst       = 1'b0;
        model_reset();
        pulse(1'b0, -320, 256);
        check("R1 first strobe no blank", 4'b1010, 1'b0, 1'b1);

        // R8: two half cycles from the table at unity index, across the half wrap
        do_reset();
        peak = 0;
        for (int n = 0; n < 64; n++) begin
            tstep("R8 table", 256, c);
            if (c > peak) peak = c;
        end
        n_chk++;
        if (peak != 15) begin
            n_fail++;
            $display("FAIL R8 peak: actual=%0d expected=15", peak);
        end

        // R9: half index lowers the peak
        peak = 0;
        for (int n = 0; n < 32; n++) begin
            tstep("R9 scaled table", 128, c);
            if (c > peak) peak = c;
        end
        n_chk++;
        if (peak != 7) begin
            n_fail++;
            $display("FAIL R9 peak: actual=%0d expected=7", peak);
        end

        // R10: external strobes between table strobes do not move the index
        for (int n = 0; n < 5; n++) tstep("R10 table lead-in", 256, c);
        for (int n = 0; n < 3; n++) begin
            pulse(1'b0, 64, 256);
            model(ext_code(64, 256), 0, ec, ep, en);
            check("R10 external interleave", ec, ep, en);
        end
        tstep("R10 table resume", 256, c);
        tstep("R10 table resume", 256, c);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule